// File: doc/BRIEF.md
# 4B/5B Transmit Code-Group Encoder with Test-Pattern Injector

This block sits on the transmit side of a 100 Mb/s physical coding sublayer. Each clock it takes one nibble from the MAC-side interface (`txd`, `tx_en`, `tx_er`) and produces one 5-bit code-group. Every output is registered, so it appears one clock after the nibble that caused it. Frames are delimited on the line. The start delimiter pair takes the place of the first preamble byte, and the end delimiter pair follows the drop of `tx_en`. Between frames the idle code-group fills the line. While `tx_er` is high, each data code-group inside a frame is replaced by the halt code-group.

For line testing, a 2-bit select replaces the whole output with one of three repeating patterns that carry no delimiters: a far-end-fault pattern, a slow square wave and a fast square wave. A symbol-mode input bypasses encoding. In symbol mode the raw 5-bit symbol `{tx_er, txd}` is passed through, and test patterns are suppressed.

The group lengths of the patterns are parameters. A generate option chooses a registered or a combinational output.

Top module: `txcg_encoder`

## Requirements
- R1: After reset, `cg_out` is the idle code-group 11111, and it stays at idle while `tx_en` is low and no test pattern is selected.
- R2: Inside a frame, each data nibble is sent as its code-group. Nibbles 0 to F map to: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R3: On the first nibble with `tx_en` high, the output is J=11000. On the next nibble it is K=10001, whatever that nibble is. The nibbles after that are encoded as data.
- R4: On the first nibble with `tx_en` low after data, the output is T=01101. On the next nibble it is R=00111. Idle follows.
- R5: A data nibble with both `tx_en` and `tx_er` high is sent as HALT=00100.
- R6: `tx_er` has no effect on the J, K, T and R code-groups.
- R7: If `tx_en` drops on the nibble that would carry K, the output is still J, K, and then T, R, and then idle.
- R8: With `test_sel`=11 the output repeats two groups of 11111 followed by two groups of 00000. This gives 10 ones then 10 zeros.
- R9: With `test_sel`=10 the output repeats 16 groups of 11111 followed by 16 groups of 00000. This gives 80 ones then 80 zeros.
- R10: With `test_sel`=01 the output repeats 16 groups of 11111 followed by one group of 11110. This gives 84 ones then a single zero. Every pattern starts at its first group when it is selected.
- R11: With `symbol_mode` high the output is `{tx_er, txd}`, and no test pattern or delimiter is produced.
- R12: While a test pattern is selected, `tx_en` and `tx_er` have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Transmit error from the MAC; the high symbol bit in symbol mode |
| txd | input | 4 | Transmit nibble |
| symbol_mode | input | 1 | Pass-through of unencoded symbols |
| test_sel | input | 2 | Test pattern select: 00 off, 01 far-end fault, 10 slow square, 11 fast square |
| cg_out | output | 5 | Code-group, MSB sent first |

## Verification
Two functions can meet on the same nibble. The first is error substitution and framing: `tx_er` is held high while J and K are produced and again while T and R are produced. The bench checks that only the data code-groups in between turn into HALT. The second is the test-pattern override and frame start: `tx_en` rises on the same cycle a pattern is selected. The bench expects the first pattern group rather than J. Symbol mode is then raised on top of a selected pattern, and the bench expects the raw symbol.

// File: rtl/txcg_pkg.sv
package txcg_pkg;

   localparam logic [4:0] CG_IDLE = 5'b11111;
   localparam logic [4:0] CG_J    = 5'b11000;
   localparam logic [4:0] CG_K    = 5'b10001;
   localparam logic [4:0] CG_T    = 5'b01101;
   localparam logic [4:0] CG_R    = 5'b00111;
   localparam logic [4:0] CG_HALT = 5'b00100;

   typedef enum logic [2:0] {
      SYM_IDLE, SYM_J, SYM_K, SYM_DATA, SYM_HALT, SYM_T, SYM_R
   } sym_e;

   typedef enum logic [1:0] {
      FR_IDLE, FR_K, FR_DATA, FR_R
   } frame_st_e;

   typedef enum logic [1:0] {
      TP_OFF  = 2'b00,
      TP_FEFI = 2'b01,
      TP_SLOW = 2'b10,
      TP_FAST = 2'b11
   } tpat_e;

   function automatic logic [4:0] enc4b5b(input logic [3:0] nib);
      logic [4:0] c;
      case (nib)
         4'h0: c = 5'b11110;
         4'h1: c = 5'b01001;
         4'h2: c = 5'b10100;
         4'h3: c = 5'b10101;
         4'h4: c = 5'b01010;
         4'h5: c = 5'b01011;
         4'h6: c = 5'b01110;
         4'h7: c = 5'b01111;
         4'h8: c = 5'b10010;
         4'h9: c = 5'b10011;
         4'hA: c = 5'b10110;
         4'hB: c = 5'b10111;
         4'hC: c = 5'b11010;
         4'hD: c = 5'b11011;
         4'hE: c = 5'b11100;
         default: c = 5'b11101;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/txcg_frame_fsm.sv
module txcg_frame_fsm
   import txcg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic frame_en,
   input  logic tx_en,
   input  logic tx_er,
   output sym_e sym
);

   frame_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      sym  = SYM_IDLE;
      case (st_q)
         FR_IDLE: begin
            if (tx_en) begin
               sym  = SYM_J;
               st_d = FR_K;
            end
         end
         FR_K: begin
            sym  = SYM_K;
            st_d = FR_DATA;
         end
         FR_DATA: begin
            if (tx_en) begin
               sym = tx_er ? SYM_HALT : SYM_DATA;
            end else begin
               sym  = SYM_T;
               st_d = FR_R;
            end
         end
         default: begin
            sym  = SYM_R;
            st_d = FR_IDLE;
         end
      endcase
      if (!frame_en) st_d = FR_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= FR_IDLE;
      else        st_q <= st_d;
   end

   // R3: K always follows J, and data follows K
   p_j_then_k_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_en && st_q == FR_IDLE && tx_en) |=> (st_q == FR_K));
   p_k_then_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_en && st_q == FR_K) |=> (st_q == FR_DATA));
   // R4: end of data leads to R, R leads to idle
   p_data_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_en && st_q == FR_DATA && !tx_en) |=> (st_q == FR_R));
   p_r_then_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FR_R) |=> (st_q == FR_IDLE));

endmodule

// File: rtl/txcg_test_pattern.sv
module txcg_test_pattern
   import txcg_pkg::*;
#(
   parameter int FEFI_ONES   = 84,
   parameter int SLOW_HALF   = 16,
   parameter int FAST_HALF   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  tpat_e      sel,
   output logic [4:0] pat
);

   localparam int FEFI_LEN = (FEFI_ONES + 1) / 5;
   localparam int SLOW_LEN = 2 * SLOW_HALF;
   localparam int FAST_LEN = 2 * FAST_HALF;
   localparam int MAX_A    = (FEFI_LEN > SLOW_LEN) ? FEFI_LEN : SLOW_LEN;
   localparam int MAX_LEN  = (MAX_A > FAST_LEN) ? MAX_A : FAST_LEN;
   localparam int CW       = $clog2(MAX_LEN + 1);

   generate
      if ((FEFI_ONES + 1) % 5 != 0 || FEFI_ONES < 4)
         $error("FEFI_ONES+1 must be a multiple of 5");
      if (SLOW_HALF < 1 || FAST_HALF < 1)
         $error("square wave half periods must be at least one group");
   endgenerate

   tpat_e         sel_q;
   logic [CW-1:0] cnt_q, eff, len;

   always_comb begin
      eff = (sel != sel_q) ? '0 : cnt_q;
      case (sel)
         TP_FEFI: len = CW'(FEFI_LEN);
         TP_SLOW: len = CW'(SLOW_LEN);
         default: len = CW'(FAST_LEN);
      endcase
      case (sel)
         TP_FEFI: pat = (eff == CW'(FEFI_LEN - 1)) ? 5'b11110 : 5'b11111;
         TP_SLOW: pat = (eff < CW'(SLOW_HALF)) ? 5'b11111 : 5'b00000;
         TP_FAST: pat = (eff < CW'(FAST_HALF)) ? 5'b11111 : 5'b00000;
         default: pat = CG_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= TP_OFF;
         cnt_q <= '0;
      end else begin
         sel_q <= sel;
         if (!active || eff == len - 1'b1) cnt_q <= '0;
         else                              cnt_q <= eff + 1'b1;
      end
   end

   // R8: fast square counter stays inside its period
   p_fast_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q == TP_FAST && sel == TP_FAST) |-> (cnt_q < CW'(FAST_LEN)));
   // R10: a newly selected pattern starts at group zero
   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (active && sel != sel_q && len > 1) |=> (cnt_q == 1));

endmodule

// File: rtl/txcg_encoder.sv
module txcg_encoder
   import txcg_pkg::*;
#(
   parameter bit OUT_REG          = 1'b1,
   parameter int FEFI_ONES        = 84,
   parameter int SLOW_HALF_GROUPS = 16,
   parameter int FAST_HALF_GROUPS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_en,
   input  logic       tx_er,
   input  logic [3:0] txd,
   input  logic       symbol_mode,
   input  logic [1:0] test_sel,
   output logic [4:0] cg_out
);

   logic       test_on, frame_en;
   sym_e       sym;
   logic [4:0] pat, code_d;
   tpat_e      sel;

   assign sel      = tpat_e'(test_sel);
   assign test_on  = !symbol_mode && (sel != TP_OFF);
   assign frame_en = !symbol_mode && !test_on;

   txcg_frame_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_en (frame_en),
      .tx_en    (tx_en),
      .tx_er    (tx_er),
      .sym      (sym)
   );

   txcg_test_pattern #(
      .FEFI_ONES (FEFI_ONES),
      .SLOW_HALF (SLOW_HALF_GROUPS),
      .FAST_HALF (FAST_HALF_GROUPS)
   ) u_pat (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (test_on),
      .sel    (sel),
      .pat    (pat)
   );

   always_comb begin
      if (symbol_mode)  code_d = {tx_er, txd};
      else if (test_on) code_d = pat;
      else begin
         case (sym)
            SYM_J:    code_d = CG_J;
            SYM_K:    code_d = CG_K;
            SYM_T:    code_d = CG_T;
            SYM_R:    code_d = CG_R;
            SYM_HALT: code_d = CG_HALT;
            SYM_DATA: code_d = enc4b5b(txd);
            default:  code_d = CG_IDLE;
         endcase
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         logic [4:0] cg_q;
         always_ff @(posedge clk) begin
            if (!rst_n) cg_q <= CG_IDLE;
            else        cg_q <= code_d;
         end
         assign cg_out = cg_q;

         // R11: symbol mode passes the raw symbol one clock later
         p_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
            symbol_mode |=> (cg_out == {$past(tx_er), $past(txd)}));
         // R5: halt decision reaches the output
         p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_en && sym == SYM_HALT) |=> (cg_out == CG_HALT));
         // R6: start delimiter unaffected by tx_er
         p_delim_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_en && sym == SYM_J) |=> (cg_out == CG_J));
         // R12: square waves carry only all-ones or all-zeros groups
         p_square_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (test_on && test_sel[1]) |=> (cg_out == 5'b11111 || cg_out == 5'b00000));
      end else begin : g_comb
         assign cg_out = code_d;
      end
   endgenerate

endmodule

// File: tb/tb_txcg_encoder.sv
module tb_txcg_encoder;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tx_en, tx_er, symbol_mode;
   logic [3:0] txd;
   logic [1:0] test_sel;
   logic [4:0] cg_out;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   txcg_encoder dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
      .symbol_mode(symbol_mode), .test_sel(test_sel), .cg_out(cg_out)
   );

   // nibble -> code-group table from R2
   localparam logic [8:0] VEC [16] = '{
      {4'h0,5'b11110},{4'h1,5'b01001},{4'h2,5'b10100},{4'h3,5'b10101},
      {4'h4,5'b01010},{4'h5,5'b01011},{4'h6,5'b01110},{4'h7,5'b01111},
      {4'h8,5'b10010},{4'h9,5'b10011},{4'hA,5'b10110},{4'hB,5'b10111},
      {4'hC,5'b11010},{4'hD,5'b11011},{4'hE,5'b11100},{4'hF,5'b11101}};

   localparam logic [4:0] E_IDLE = 5'b11111, E_J = 5'b11000, E_K = 5'b10001,
                          E_T = 5'b01101, E_R = 5'b00111, E_H = 5'b00100;

   task automatic chk(input string req, input logic [4:0] exp);
      n_chk++;
      if (cg_out !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, cg_out, exp, $time);
      end
   endtask

   // drive at negedge, the registered result is visible at the next negedge
   task automatic step(input logic en, input logic er, input logic [3:0] d);
      tx_en = en; tx_er = er; txd = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tx_en = 0; tx_er = 0; txd = 0; symbol_mode = 0; test_sel = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset", E_IDLE);
      step(0, 1, 4'h3); chk("R1 idle", E_IDLE);

      // R2/R3/R4: full frame walking the vector table
      step(1, 0, 4'h5); chk("R3 J", E_J);
      step(1, 0, 4'h5); chk("R3 K", E_K);
      for (int i = 0; i < 16; i++) begin
         step(1, 0, VEC[i][8:5]);
         chk("R2 data", VEC[i][4:0]);
      end
      step(0, 0, 4'h0); chk("R4 T", E_T);
      step(0, 0, 4'h0); chk("R4 R", E_R);
      step(0, 0, 4'h0); chk("R4 idle", E_IDLE);

      // R5/R6: tx_er across delimiters and data
      step(1, 1, 4'h5); chk("R6 J under error", E_J);
      step(1, 1, 4'h5); chk("R6 K under error", E_K);
      step(1, 0, 4'h9); chk("R2 data 9", 5'b10011);
      step(1, 1, 4'h9); chk("R5 halt", E_H);
      step(1, 1, 4'h0); chk("R5 halt", E_H);
      step(0, 1, 4'h0); chk("R6 T under error", E_T);
      step(0, 1, 4'h0); chk("R6 R under error", E_R);
      step(0, 0, 4'h0); chk("R4 idle", E_IDLE);

      // R7: tx_en drops on the K nibble
      step(1, 0, 4'h5); chk("R7 J", E_J);
      step(0, 0, 4'h0); chk("R7 K", E_K);
      step(0, 0, 4'h0); chk("R7 T", E_T);
      step(0, 0, 4'h0); chk("R7 R", E_R);
      step(0, 0, 4'h0); chk("R7 idle", E_IDLE);

      // R8 fast square, R12 tx_en rising with the select
      test_sel = 2'b11;
      for (int i = 0; i < 12; i++) begin
         step(i < 3, 1'b1, 4'h2);
         chk("R8 R12 fast square", ((i % 4) < 2) ? 5'b11111 : 5'b00000);
      end
      test_sel = 2'b00; step(0, 0, 0); chk("R1 idle after test", E_IDLE);

      // R9 slow square
      test_sel = 2'b10;
      for (int i = 0; i < 40; i++) begin
         step(0, 0, 4'h0);
         chk("R9 slow square", ((i % 32) < 16) ? 5'b11111 : 5'b00000);
      end

      // R10 far-end fault, switched directly from slow
      test_sel = 2'b01;
      for (int i = 0; i < 36; i++) begin
         step(0, 0, 4'h0);
         chk("R10 fefi", ((i % 17) == 16) ? 5'b11110 : 5'b11111);
      end

      // R11 symbol mode overrides a selected pattern
      symbol_mode = 1'b1;
      step(0, 1, 4'hA); chk("R11 raw symbol", 5'b11010);
      step(1, 0, 4'h3); chk("R11 raw symbol", 5'b00011);
      step(1, 0, 4'h0); chk("R11 raw zero", 5'b00000);
      symbol_mode = 1'b0; test_sel = 2'b00;
      step(0, 0, 4'h0); chk("R11 exit idle", E_IDLE);

      // R1 reset mid-frame
      step(1, 0, 4'h5); chk("R3 J", E_J);
      rst_n = 1'b0; step(1, 0, 4'h5); rst_n = 1'b1;
      chk("R1 reset mid-frame", E_IDLE);
      tx_en = 0;
      step(0, 0, 4'h0); chk("R1 idle after reset", E_IDLE);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule